// File: doc/BRIEF.md
# Inter-Processor Interrupt Register File

This block holds the small set of shared registers through which four processor nodes signal one another. Each node owns a one-bit doorbell register that any node may set or clear over a common register port. A shared status word shows which doorbells are pending and which nodes saw their last access to the external bus bridge end in error. A per-node enable mask decides which nodes receive the bridge's shared interrupt line.

Each node gets one level-sensitive interrupt output. It is high while that node's doorbell is set, or while the bridge interrupt is active and the node's enable bit is set. Bus-error status bits are sticky. Software clears them by writing one fixed code to the status word. The doorbell mirror bits in the same word follow their doorbells directly.

The register port uses byte addresses that must be word aligned. The layout is:

| Byte offset | Register |
|---|---|
| 0x00 | Status word |
| 0x04, 0x08, 0x0C, 0x10 | Doorbells of nodes 0 to 3 |
| 0x14 | Enable mask |

Reads return data one cycle after the request.

Top module: `ipi_regfile`

## Requirements
- R1: After reset, every doorbell, bus-error bit and enable bit is 0, `node_irq` is 0, and a read of the status word returns 0.
- R2: A write to doorbell n (byte offset 4*(n+1)) with bit 0 = 1 sets that doorbell, and a write with bit 0 = 0 clears it. Bits 31..1 of the written word have no effect, and the other doorbells keep their values.
- R3: A read of doorbell n returns the doorbell in bit 0 and zeros in bits 31..1.
- R4: Status bits 8+n read as 1 exactly while doorbell n is set.
- R5: A one-cycle pulse on `berr_evt[n]` sets status bit n, and the bit stays set after the pulse ends.
- R6: A write of exactly 0x0000_0080 to the status word clears all bus-error bits. A write of any other value to the status word leaves them unchanged.
- R7: If a bus-error pulse arrives in the same cycle as the clearing write, that node's bus-error bit ends up set.
- R8: The enable mask sits at byte offset 0x14 in bits 3..0 (bit n for node n) and reads back as written. The bridge interrupt reaches node n only when bit n is 1.
- R9: `node_irq[n]` equals doorbell n OR (enable bit n AND `bridge_irq`), registered, so it changes one clock after the state it depends on.
- R10: Reads of unmapped or misaligned addresses return 0, and writes to them change no register.
- R11: `rdata` is loaded on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| berr_evt | input | NODES (4) | One-cycle bus-error pulse per node from the bridge |
| bridge_irq | input | 1 | Shared bridge interrupt level |
| node_irq | output | NODES (4) | Interrupt level to each node |

## Verification
The bench targets the following corner cases:

- **Clear code:** it writes near-miss values such as 0x180 and 0x81 to the status word. A design that compared only the low byte, or tested only bit 7, would wipe the sticky errors on those writes.
- **Race between set and clear:** it puts a bus-error pulse and the clearing write in the same cycle. A design that gave the clear priority would lose that error.
- **Doorbell writes:** it writes doorbells with high garbage bits and bit 0 clear. A design that decoded any nonzero word as a set would raise the interrupt.
- **Address decode:** it accesses a misaligned address and an address just past the map. A design with a loose decode would alias them onto a doorbell.
- **Masking:** it drives the bridge interrupt with a partial mask. A design with a missing or inverted mask would interrupt the wrong nodes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W   = 32;
  localparam int PEND_LSB = 8;
  localparam logic [DATA_W-1:0] BERR_CLR_CODE = 32'h0000_0080;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_BELL   = 2'd2,
    SEL_MASK   = 2'd3
  } sel_kind_e;
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
  import ipi_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (word == '0) begin
        kind = SEL_STATUS;
      end else if (int'(word) <= NODES) begin
        kind = SEL_BELL;
        idx  = IDX_W'(int'(word) - 1);
      end else if (int'(word) == NODES + 1) begin
        kind = SEL_MASK;
      end
    end
  end
endmodule

// File: rtl/ipi_node_flags.sv
module ipi_node_flags #(
  parameter int NODES = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_bell,
  input  logic [IDX_W-1:0] idx,
  input  logic             bit0,
  output logic [NODES-1:0] flags
);
  for (genvar n = 0; n < NODES; n++) begin : g_bell
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[n] <= 1'b0;
      end else if (wr_bell && (int'(idx) == n)) begin
        flags[n] <= bit0;
      end
    end
  end
endmodule

// File: rtl/ipi_berr_sticky.sv
module ipi_berr_sticky #(
  parameter int NODES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] evt,
  input  logic             clr,
  output logic [NODES-1:0] q
);
  logic [NODES-1:0] keep;
  assign keep = clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= keep | evt;
  end
endmodule

// File: rtl/ipi_irq_merge.sv
module ipi_irq_merge #(
  parameter int NODES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NODES-1:0] flags,
  input  logic [NODES-1:0] enables,
  input  logic             bridge_irq,
  output logic [NODES-1:0] node_irq
);
  logic [NODES-1:0] gated;
  assign gated = enables & {NODES{bridge_irq}};

  always_ff @(posedge clk) begin
    if (rst) node_irq <= '0;
    else     node_irq <= flags | gated;
  end
endmodule

// File: rtl/ipi_regfile.sv
module ipi_regfile
  import ipi_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NODES-1:0]  berr_evt,
  input  logic              bridge_irq,
  output logic [NODES-1:0]  node_irq
);
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

  sel_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic [NODES-1:0] ipi_q;
  logic [NODES-1:0] berr_q;
  logic [NODES-1:0] mask_q;
  logic             berr_clr;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_next;

  ipi_addr_dec #(.NODES(NODES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  ipi_node_flags #(.NODES(NODES), .IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .wr_bell (wr_en && (kind == SEL_BELL)),
    .idx     (idx),
    .bit0    (wdata[0]),
    .flags   (ipi_q)
  );

  assign berr_clr = wr_en && (kind == SEL_STATUS) && (wdata == BERR_CLR_CODE);

  ipi_berr_sticky #(.NODES(NODES)) u_berr (
    .clk (clk),
    .rst (rst),
    .evt (berr_evt),
    .clr (berr_clr),
    .q   (berr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (wr_en && (kind == SEL_MASK)) mask_q <= wdata[NODES-1:0];
  end

  ipi_irq_merge #(.NODES(NODES)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .flags      (ipi_q),
    .enables    (mask_q),
    .bridge_irq (bridge_irq),
    .node_irq   (node_irq)
  );

  always_comb begin
    status_word = '0;
    status_word[NODES-1:0] = berr_q;
    status_word[PEND_LSB +: NODES] = ipi_q;
  end

  always_comb begin
    rd_next = '0;
    case (kind)
      SEL_STATUS: rd_next = status_word;
      SEL_BELL:   rd_next[0] = ipi_q[idx];
      SEL_MASK:   rd_next[NODES-1:0] = mask_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/ipi_regfile_chk.sv
module ipi_regfile_chk #(
  parameter int NODES  = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NODES-1:0]  berr_evt,
  input logic              bridge_irq,
  input logic [NODES-1:0]  node_irq,
  input logic [NODES-1:0]  ipi_q,
  input logic [NODES-1:0]  berr_q,
  input logic [NODES-1:0]  mask_q
);
  logic status_wr;
  assign status_wr = wr_en && (addr == '0);

  for (genvar n = 0; n < NODES; n++) begin : g_node
    AST_BELL_SET: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'((n + 1) * 4) && wdata[0]) |=> ipi_q[n]); // R2
    AST_BELL_CLR: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'((n + 1) * 4) && !wdata[0]) |=> !ipi_q[n]); // R2
    AST_BERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      berr_evt[n] |=> berr_q[n]); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      (!ipi_q[n] && !(mask_q[n] && bridge_irq)) |=> !node_irq[n]); // R8
    AST_IRQ_BELL: assert property (@(posedge clk) disable iff (rst)
      ipi_q[n] |=> node_irq[n]); // R9
  end

  AST_BERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (status_wr && wdata == 32'h80) |=> ((berr_q & ~$past(berr_evt)) == '0)); // R6
  AST_BERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(status_wr && wdata == 32'h80) && berr_evt == '0) |=> $stable(berr_q)); // R6
endmodule

bind ipi_regfile ipi_regfile_chk #(.NODES(NODES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .berr_evt   (berr_evt),
  .bridge_irq (bridge_irq),
  .node_irq   (node_irq),
  .ipi_q      (ipi_q),
  .berr_q     (berr_q),
  .mask_q     (mask_q)
);

// File: tb/ipi_regfile_test.sv
module ipi_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NODES-1:0]  berr_evt = '0;
  logic              bridge_irq = 1'b0;
  logic [NODES-1:0]  node_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_regfile #(.NODES(NODES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .berr_evt(berr_evt),
    .bridge_irq(bridge_irq), .node_irq(node_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic pulse_berr(input logic [3:0] v);
    @(negedge clk);
    berr_evt = v;
    @(negedge clk);
    berr_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 node_irq after reset", 32'(node_irq), 32'h0);
    rd(8'h00, d); chk("R1 status after reset", d, 32'h0);
    rd(8'h14, d); chk("R1 mask after reset", d, 32'h0);
    rd(8'h08, d); chk("R1 bell B after reset", d, 32'h0);
  endtask

  task automatic t_doorbells();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFE);
    rd(8'h08, d); chk("R2 high bits with bit0=0 do not set", d, 32'h0);
    wr(8'h08, 32'hA5A5_0001);
    rd(8'h08, d); chk("R3 bell B reads bit0 only", d, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h00, d); chk("R4 pending mirror B and D", d, 32'h0000_0A00);
    chk("R9 irq from bells", 32'(node_irq), 32'h0000_000A);
    wr(8'h08, 32'h0);
    rd(8'h04, d); chk("R2 bell A untouched", d, 32'h0);
    rd(8'h00, d); chk("R4 pending after clear of B", d, 32'h0000_0800);
    wr(8'h10, 32'h0);
    @(negedge clk);
    chk("R9 irq cleared", 32'(node_irq), 32'h0);
  endtask

  task automatic t_berr();
    logic [31:0] d;
    pulse_berr(4'b0101);
    @(negedge clk);
    rd(8'h00, d); chk("R5 sticky bus errors", d, 32'h5);
    wr(8'h00, 32'h0000_0180);
    rd(8'h00, d); chk("R6 near-miss 0x180 keeps errors", d, 32'h5);
    wr(8'h00, 32'h0000_0081);
    rd(8'h00, d); chk("R6 near-miss 0x81 keeps errors", d, 32'h5);
    wr(8'h00, 32'h0000_0080);
    rd(8'h00, d); chk("R6 clear code empties errors", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse_berr(4'b0001);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h00; wdata = 32'h80; berr_evt = 4'b0010;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; berr_evt = '0;
    rd(8'h00, d); chk("R7 event beats clear", d, 32'h2);
    wr(8'h00, 32'h80);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFF5);
    rd(8'h14, d); chk("R8 mask readback", d, 32'h5);
    @(negedge clk);
    bridge_irq = 1'b1;
    @(negedge clk);
    chk("R8 bridge gated by mask", 32'(node_irq), 32'h5);
    wr(8'h14, 32'h2);
    @(negedge clk);
    chk("R8 mask change moves bridge irq", 32'(node_irq), 32'h2);
    bridge_irq = 1'b0;
    @(negedge clk);
    chk("R9 bridge release", 32'(node_irq), 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h05, 32'h1);
    wr(8'h18, 32'h1);
    wr(8'hFC, 32'h1);
    rd(8'h00, d); chk("R10 stray writes change nothing", d, 32'h0);
    rd(8'h14, d); chk("R10 mask untouched", d, 32'h0);
    @(negedge clk);
    chk("R10 no irq from stray writes", 32'(node_irq), 32'h0);
    rd(8'h18, d); chk("R10 read past map", d, 32'h0);
    wr(8'h0C, 32'h1);
    rd(8'h0E, d); chk("R10 misaligned read", d, 32'h0);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd(8'h0C, d); chk("R11 read bell C", d, 32'h1);
    @(negedge clk);
    addr = 8'h00;
    wr(8'h0C, 32'h0);
    @(negedge clk);
    chk("R11 rdata holds without rd_en", rdata, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_doorbells();
    t_berr();
    t_race();
    t_mask();
    t_unmapped();
    t_read_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule